// File: doc/BRIEF.md
# Prescaled Reloadable Wake-Up Timer

This block is a low-power interval timer. A 7-bit prescaler drives a 16-bit down counter, and the pair behaves as one 23-bit chain that counts down. A selectable tick source advances the chain. The source is one of several single-cycle enable pulses, each derived from a different slow clock. When a tick arrives while the whole chain reads zero, the counter reloads from the reload input, the prescaler returns to its top value, and a sticky underflow flag is set. One underflow period is therefore 128 × (reload + 1) ticks.

The flag drives two requests, and each has its own enable. The interrupt request makes the block a periodic system tick. The wake request lets the block bring the device out of power-down. The block counts independently of the core's power state. The block is not running while its run input is low. In that state it holds the prescaler at its top value and keeps the counter loaded from the reload input, so the count starts from a known state when run is raised.

Top module: `rwt_wake_timer`

## Requirements
- R1: After synchronous reset, the prescaler reads 127, the count reads 0, and the flag, interrupt request and wake request are all 0.
- R2: While run is low, each clock forces the prescaler to 127 and loads the count from the reload input, one cycle after the clock edge. No tick has any effect in this state.
- R3: Only the tick lane chosen by the source select advances the chain. Pulses on any other lane leave both the prescaler and the count unchanged.
- R4: While running, each selected tick decrements the prescaler by one. A tick that finds the prescaler at 0 sets it back to 127 and decrements the count by one, provided the count is not 0.
- R5: A tick that finds both the prescaler and the count at 0 is the underflow event. It loads the count from the reload input, sets the prescaler to 127 and sets the flag. Starting from a fresh load, the event falls on tick number 128 × (reload + 1).
- R6: The flag stays set until the clear input is asserted without a simultaneous underflow event. Clear then takes effect at the next clock edge.
- R7: When clear and an underflow event occur in the same cycle, the flag is 1 after that edge.
- R8: The interrupt request equals flag AND interrupt enable, and the wake request equals flag AND wake enable. Both are combinational, and each is independent of the other enable.
- R9: A change to the reload input while running does not alter the count in progress. The new value is used at the next underflow reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_src | input | SRC_N (2) | Single-cycle tick pulses, one lane per clock source |
| tick_sel | input | SRC_W (1) | Index of the lane that advances the chain |
| run | input | 1 | Count enable; low holds the chain in its loaded state |
| reload | input | CNT_W (16) | Value the count takes on load and on underflow |
| irq_en | input | 1 | Gates the flag onto the interrupt request |
| wake_en | input | 1 | Gates the flag onto the wake request |
| flag_clr | input | 1 | Clears the sticky underflow flag |
| count_o | output | CNT_W (16) | Current count value |
| prescale_o | output | PRE_W (7) | Current prescaler value |
| flag_o | output | 1 | Sticky underflow flag |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake-up request |

## Verification
Each tick, load and clear changes the prescaler, the count and the flag exactly one register stage later, at the next rising edge. The bench drives every input on a falling edge and reads the outputs on the following falling edge, after all ticks of a burst have been clocked in. The two requests are combinational on the flag and the enables, so they are read a moment after the enables change within the same cycle. The underflow cases are placed at the tick counts that the 128 × (reload + 1) period predicts, together with the ticks one before and one after.

// File: rtl/rwt_pkg.sv
package rwt_pkg;

    localparam int PRE_W_DEF = 7;
    localparam int CNT_W_DEF = 16;
    localparam int SRC_N_DEF = 2;

    // action taken by the loadable counter on a clock edge
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_DEC  = 2'd1,
        ACT_LOAD = 2'd2
    } cnt_act_e;

    // width of a select field for n lanes (at least one bit)
    function automatic int sel_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rwt_prescaler.sv
module rwt_prescaler #(
    parameter int PRE_W = rwt_pkg::PRE_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    output logic [PRE_W-1:0] pre_q,
    output logic             roll
);

    localparam logic [PRE_W-1:0] PRE_TOP = {PRE_W{1'b1}};

    assign roll = run && tick && (pre_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= PRE_TOP;
        end else if (!run || roll) begin
            pre_q <= PRE_TOP;
        end else if (tick) begin
            pre_q <= pre_q - 1'b1;
        end
    end

    // R2: stopped chain sits at top
    assert_idle_top_R2: assert property (@(posedge clk) disable iff (rst)
        !run |=> pre_q == PRE_TOP);

    // R4: one step down per tick while above zero
    assert_pre_step_R4: assert property (@(posedge clk) disable iff (rst)
        (run && tick && pre_q != '0) |=> pre_q == $past(pre_q) - 1'b1);

    // R3: no tick, no motion while running
    assert_pre_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> $stable(pre_q));

endmodule

// File: rtl/rwt_downcount.sv
module rwt_downcount #(
    parameter int CNT_W = rwt_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             roll,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt_q,
    output logic             terminal
);

    import rwt_pkg::*;

    cnt_act_e act;

    assign terminal = roll && (cnt_q == '0);

    always_comb begin
        if (!run || terminal) begin
            act = ACT_LOAD;
        end else if (roll) begin
            act = ACT_DEC;
        end else begin
            act = ACT_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (act)
                ACT_LOAD: cnt_q <= reload;
                ACT_DEC:  cnt_q <= cnt_q - 1'b1;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    // R5: underflow reloads from the reload input
    assert_reload_on_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (roll && cnt_q == '0) |=> cnt_q == $past(reload));

    // R9: count in progress untouched without a rollover
    assert_cnt_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (run && !roll) |=> $stable(cnt_q));

    // R4: rollover above zero steps the count down
    assert_cnt_step_R4: assert property (@(posedge clk) disable iff (rst)
        (run && roll && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/rwt_flag.sv
module rwt_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic clr,
    output logic flag_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (set_ev) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

    // R7: event wins over clear
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        set_ev |=> flag_q);

    // R6: clear alone drops the flag
    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (clr && !set_ev) |=> !flag_q);

    // R6: sticky otherwise
    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (!clr && !set_ev) |=> $stable(flag_q));

endmodule

// File: rtl/rwt_wake_timer.sv
module rwt_wake_timer #(
    parameter int PRE_W = rwt_pkg::PRE_W_DEF,
    parameter int CNT_W = rwt_pkg::CNT_W_DEF,
    parameter int SRC_N = rwt_pkg::SRC_N_DEF,
    parameter int SRC_W = rwt_pkg::sel_width(SRC_N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] tick_src,
    input  logic [SRC_W-1:0] tick_sel,
    input  logic             run,
    input  logic [CNT_W-1:0] reload,
    input  logic             irq_en,
    input  logic             wake_en,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count_o,
    output logic [PRE_W-1:0] prescale_o,
    output logic             flag_o,
    output logic             irq_o,
    output logic             wake_o
);

    logic tick;
    logic roll;
    logic terminal;

    // lane picker; an out-of-range select gives no tick
    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < SRC_N; i++) begin
            if (tick_sel == SRC_W'(i)) begin
                tick = tick_src[i];
            end
        end
    end

    rwt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .tick  (tick),
        .pre_q (prescale_o),
        .roll  (roll)
    );

    rwt_downcount #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .roll     (roll),
        .reload   (reload),
        .cnt_q    (count_o),
        .terminal (terminal)
    );

    rwt_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_ev (terminal),
        .clr    (flag_clr),
        .flag_q (flag_o)
    );

    assign irq_o  = flag_o & irq_en;
    assign wake_o = flag_o & wake_en;

    // R8: requests never raised without the flag
    assert_req_needs_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_o || wake_o) |-> flag_o);

    // R5: the underflow lands the prescaler at top with flag set
    assert_event_state_R5: assert property (@(posedge clk) disable iff (rst)
        terminal |=> (flag_o && prescale_o == {PRE_W{1'b1}}));

    // R1: reset leaves a quiet block
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!flag_o && count_o == '0));

endmodule

// File: tb/test_rwt_wake_timer.sv
module test_rwt_wake_timer;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  tick_src;
    logic [0:0]  tick_sel;
    logic        run;
    logic [15:0] reload;
    logic        irq_en;
    logic        wake_en;
    logic        flag_clr;
    logic [15:0] count_o;
    logic [6:0]  prescale_o;
    logic        flag_o;
    logic        irq_o;
    logic        wake_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rwt_wake_timer i_rwt_wake_timer (
        .clk        (clk),
        .rst        (rst),
        .tick_src   (tick_src),
        .tick_sel   (tick_sel),
        .run        (run),
        .reload     (reload),
        .irq_en     (irq_en),
        .wake_en    (wake_en),
        .flag_clr   (flag_clr),
        .count_o    (count_o),
        .prescale_o (prescale_o),
        .flag_o     (flag_o),
        .irq_o      (irq_o),
        .wake_o     (wake_o)
    );

    // {reload, ticks, expected count, expected prescaler, expected flag}
    localparam logic [55:0] VEC [0:9] = '{
        {16'd3,     16'd0,   16'd3,     7'd127, 1'b0},
        {16'd3,     16'd1,   16'd3,     7'd126, 1'b0},
        {16'd3,     16'd127, 16'd3,     7'd0,   1'b0},
        {16'd3,     16'd128, 16'd2,     7'd127, 1'b0},
        {16'd3,     16'd300, 16'd1,     7'd83,  1'b0},
        {16'd0,     16'd127, 16'd0,     7'd0,   1'b0},
        {16'd0,     16'd128, 16'd0,     7'd127, 1'b1},
        {16'd2,     16'd384, 16'd2,     7'd127, 1'b1},
        {16'd2,     16'd385, 16'd2,     7'd126, 1'b1},
        {16'hFFFF,  16'd5,   16'hFFFF,  7'd122, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // called on a falling edge; returns on a falling edge
    task automatic ticks(input int n, input int lane);
        if (n > 0) begin
            tick_src[lane] = 1'b1;
            repeat (n) @(negedge clk);
            tick_src = '0;
        end
    endtask

    task automatic restart(input logic [15:0] r);
        run      = 1'b0;
        reload   = r;
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        run      = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tick_src = '0; tick_sel = '0; run = 1'b0;
        reload = 16'h0; irq_en = 1'b1; wake_en = 1'b1; flag_clr = 1'b0;
        @(negedge clk); @(negedge clk);
        // R1
        check("R1 prescaler", 32'(prescale_o), 32'd127);
        check("R1 count", 32'(count_o), 32'd0);
        check("R1 flag", 32'(flag_o), 32'd0);
        check("R1 requests", 32'({irq_o, wake_o}), 32'd0);
        rst = 1'b0;
        reload = 16'h1234;
        @(negedge clk);
        // R2 load while stopped, ticks ignored
        check("R2 load", 32'(count_o), 32'h1234);
        ticks(5, 0);
        check("R2 stopped tick count", 32'(count_o), 32'h1234);
        check("R2 stopped tick prescaler", 32'(prescale_o), 32'd127);

        // R4 R5 vector walk
        for (int k = 0; k < 10; k++) begin
            restart(VEC[k][55:40]);
            ticks(int'(VEC[k][39:24]), 0);
            check($sformatf("R4/R5 row %0d count", k), 32'(count_o), 32'(VEC[k][23:8]));
            check($sformatf("R4/R5 row %0d prescaler", k), 32'(prescale_o), 32'(VEC[k][7:1]));
            check($sformatf("R5 row %0d flag", k), 32'(flag_o), 32'(VEC[k][0]));
        end

        // R2 dropping run mid-count restores the loaded state
        restart(16'd7);
        ticks(200, 0);
        run = 1'b0;
        @(negedge clk);
        check("R2 stop count", 32'(count_o), 32'd7);
        check("R2 stop prescaler", 32'(prescale_o), 32'd127);

        // R3 unselected lane ignored, selected lane counts
        restart(16'd7);
        tick_sel = 1'b0;
        ticks(10, 1);
        check("R3 other lane prescaler", 32'(prescale_o), 32'd127);
        check("R3 other lane count", 32'(count_o), 32'd7);
        tick_sel = 1'b1;
        ticks(10, 1);
        check("R3 chosen lane prescaler", 32'(prescale_o), 32'd117);
        tick_sel = 1'b0;

        // R6 sticky flag, R8 gating
        restart(16'd0);
        ticks(128, 0);
        repeat (20) @(negedge clk);
        check("R6 sticky", 32'(flag_o), 32'd1);
        irq_en = 1'b1; wake_en = 1'b0; #1;
        check("R8 irq only", 32'({irq_o, wake_o}), 32'b10);
        irq_en = 1'b0; wake_en = 1'b1; #1;
        check("R8 wake only", 32'({irq_o, wake_o}), 32'b01);
        irq_en = 1'b0; wake_en = 1'b0; #1;
        check("R8 none", 32'({irq_o, wake_o}), 32'b00);
        irq_en = 1'b1; wake_en = 1'b1;
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check("R6 clear", 32'(flag_o), 32'd0);
        check("R8 cleared requests", 32'({irq_o, wake_o}), 32'd0);

        // R7 clear colliding with underflow
        ticks(127, 0);
        check("R7 pre-event flag", 32'(flag_o), 32'd0);
        tick_src[0] = 1'b1; flag_clr = 1'b1;
        @(negedge clk);
        tick_src = '0; flag_clr = 1'b0;
        check("R7 collision", 32'(flag_o), 32'd1);

        // R9 reload change mid-count
        restart(16'd5);
        ticks(128, 0);
        reload = 16'd9;
        @(negedge clk);
        check("R9 count kept", 32'(count_o), 32'd4);
        ticks(639, 0);
        check("R9 before event", 32'(count_o), 32'd0);
        check("R9 no early flag", 32'(flag_o), 32'd0);
        ticks(1, 0);
        check("R9 new reload", 32'(count_o), 32'd9);
        check("R9 flag", 32'(flag_o), 32'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule